// File: doc/BRIEF.md
# SPI Configuration Status Poller

This block sits on the master side of an SPI link to a device that is being configured. It samples the device's one-byte status register over and over until the device is no longer busy and a condition chosen by the requester holds, and then hands back the final status byte. A client starts a poll with a valid/ready request that carries an 8-bit condition mask. The block answers with a one-cycle done pulse that carries the status byte, an error flag and a timeout flag.

Each status sample uses two separate chip-select frames. Each frame shifts out the one-byte read-status opcode and captures one byte from MISO. The byte from the first frame is always thrown away, and only the second byte is judged. A bounded sample counter stops the poll once a parameterised number of samples has been taken. The SPI engine runs in mode 0 at a rate set by a divider input. Software must hold that input stable while a poll is in flight.

The request side has back-pressure: `req_ready` is high only while the block is idle, and a request is taken on the edge where `req_valid` and `req_ready` are both high. The response side has none. The done pulse lasts one cycle and cannot be stalled.

Top module: `spi_status_poller`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, `spi_cs_n` is 1 and `spi_sclk` is 0.
- R2: A poll that takes n samples produces exactly 2n chip-select frames. Each frame has exactly 8 rising SCLK edges, and MOSI is 0 at every rising edge, because the read-status opcode is 0x00 and is sent MSB first.
- R3: Within each sample, the byte captured in the first frame has no effect on the outcome. Only the second frame's byte is judged and reported.
- R4: If a judged byte has bit 2 (protocol violation) or bit 3 (link error) set, polling stops at once. The response then has `rsp_err`=1, `rsp_timeout`=0, and that byte as `rsp_status`.
- R5: If a judged byte has bit 0 (busy) set and neither error bit set, it is discarded and another sample follows.
- R6: If a judged byte has busy clear and neither error bit set, polling ends successfully (both flags 0, status = that byte) when the mask is zero or when the byte ANDed with the mask is nonzero. Otherwise another sample follows. Bit 1 is the ready bit that a mask usually selects.
- R7: When MAX_SAMPLES samples have been judged without an end, the response has `rsp_timeout`=1, `rsp_err`=0, and the last judged byte as `rsp_status`.
- R8: With divider value d, `rsp_valid` goes high n·(34·(d+1)+5) clock edges after the request handshake edge, where n is the number of samples.
- R9: `req_ready` is 0 from the handshake until the response, and `rsp_valid` is high for exactly one cycle.
- R10: SCLK idles low and is low whenever chip-select is deasserted. Each SCLK high phase lasts d+1 clock cycles, so a frame holds SCLK high for 8·(d+1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div | input | DIV_W | SCLK half-period minus one, in clock cycles |
| req_valid | input | 1 | Poll request valid |
| req_ready | output | 1 | Block idle, request can be taken |
| req_mask | input | 8 | Condition mask for the request |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_status | output | 8 | Final judged status byte |
| rsp_err | output | 1 | Error bit seen in a judged byte |
| rsp_timeout | output | 1 | Sample budget exhausted |
| spi_sclk | output | 1 | SPI clock, mode 0 |
| spi_cs_n | output | 1 | SPI chip-select, active low |
| spi_mosi | output | 1 | SPI master-out data |
| spi_miso | input | 1 | SPI master-in data |

## Verification
One sample costs two frames of 17 half-periods each, plus five control cycles. The response is therefore due exactly n·(34·(d+1)+5) edges after the handshake edge. The bench computes n, the status and the flags from its own model of the sample script and the mask, then counts edges from the handshake until it sees `rsp_valid` at a falling clock edge, and compares that count with the formula. All other checks read counters that the bench accumulates at falling edges during the poll: frames, SCLK rises, SCLK-high cycles, nonzero MOSI bits and cycles with `req_ready` high. These are compared when the done pulse arrives, and once more on the cycle after it to confirm the pulse has dropped.

// File: rtl/spsp_pkg.sv
package spsp_pkg;
  localparam int STAT_W = 8;
  localparam logic [STAT_W-1:0] OPC_READ_STATUS = 8'h00;
  localparam int BIT_BUSY  = 0;
  localparam int BIT_READY = 1;
  localparam int BIT_VIOL  = 2;
  localparam int BIT_LERR  = 3;

  typedef enum logic [1:0] {
    V_RETRY = 2'd0,
    V_DONE  = 2'd1,
    V_FAIL  = 2'd2
  } verdict_t;

  typedef enum logic [2:0] {
    E_IDLE, E_LEAD, E_HI, E_LO, E_TAIL
  } eng_state_t;

  typedef enum logic [2:0] {
    P_IDLE, P_KICK1, P_WAIT1, P_KICK2, P_WAIT2, P_EVAL
  } poll_state_t;
endpackage

// File: rtl/spsp_byte_engine.sv
module spsp_byte_engine
  import spsp_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div,
  input  logic              start,
  input  logic [STAT_W-1:0] tx_byte,
  output logic              done,
  output logic [STAT_W-1:0] rx_byte,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso
);
  localparam int BCNT_W = $clog2(STAT_W);

  eng_state_t        st;
  logic [DIV_W-1:0]  hcnt;
  logic [BCNT_W-1:0] bitn;
  logic [STAT_W-1:0] tx_sh;
  logic [STAT_W-1:0] rx_sh;
  logic              tick;

  assign tick    = (hcnt == div);
  assign rx_byte = rx_sh;
  assign mosi    = tx_sh[STAT_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= E_IDLE;
      hcnt  <= '0;
      bitn  <= '0;
      tx_sh <= '0;
      rx_sh <= '0;
      sclk  <= 1'b0;
      cs_n  <= 1'b1;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st != E_IDLE) hcnt <= tick ? '0 : hcnt + 1'b1;
      case (st)
        E_IDLE: if (start) begin
          tx_sh <= tx_byte;
          cs_n  <= 1'b0;
          bitn  <= '0;
          hcnt  <= '0;
          st    <= E_LEAD;
        end
        E_LEAD, E_LO: if (tick) begin
          sclk  <= 1'b1;
          rx_sh <= {rx_sh[STAT_W-2:0], miso};
          st    <= E_HI;
        end
        E_HI: if (tick) begin
          sclk <= 1'b0;
          if (bitn == BCNT_W'(STAT_W-1)) begin
            cs_n <= 1'b1;
            st   <= E_TAIL;
          end else begin
            tx_sh <= {tx_sh[STAT_W-2:0], 1'b0};
            bitn  <= bitn + 1'b1;
            st    <= E_LO;
          end
        end
        E_TAIL: if (tick) begin
          done <= 1'b1;
          st   <= E_IDLE;
        end
        default: st <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spsp_sample_counter.sv
module spsp_sample_counter #(
  parameter int MAX_SAMPLES = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic last
);
  localparam int CW = $clog2(MAX_SAMPLES + 1);
  logic [CW-1:0] cnt;

  assign last = (cnt == CW'(MAX_SAMPLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (bump)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spsp_status_judge.sv
module spsp_status_judge
  import spsp_pkg::*;
(
  input  logic [STAT_W-1:0] sample,
  input  logic [STAT_W-1:0] mask,
  output verdict_t          verdict
);
  logic err_seen, busy_seen, cond_hit;

  assign err_seen  = sample[BIT_VIOL] | sample[BIT_LERR];
  assign busy_seen = sample[BIT_BUSY];
  assign cond_hit  = (mask == '0) | (|(sample & mask));

  always_comb begin
    if (err_seen)       verdict = V_FAIL;
    else if (busy_seen) verdict = V_RETRY;
    else if (cond_hit)  verdict = V_DONE;
    else                verdict = V_RETRY;
  end
endmodule

// File: rtl/spsp_poll_ctrl.sv
module spsp_poll_ctrl
  import spsp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [STAT_W-1:0] req_mask,
  output logic              eng_start,
  input  logic              eng_done,
  input  logic [STAT_W-1:0] eng_rx,
  output logic [STAT_W-1:0] sample_q,
  output logic [STAT_W-1:0] mask_q,
  input  verdict_t          verdict,
  input  logic              budget_last,
  output logic              cnt_clear,
  output logic              cnt_bump,
  output logic              rsp_valid,
  output logic [STAT_W-1:0] rsp_status,
  output logic              rsp_err,
  output logic              rsp_timeout
);
  poll_state_t st;

  assign req_ready = (st == P_IDLE);
  assign eng_start = (st == P_KICK1) || (st == P_KICK2);
  assign cnt_clear = req_valid && req_ready;
  assign cnt_bump  = (st == P_EVAL) && (verdict == V_RETRY) && !budget_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= P_IDLE;
      mask_q      <= '0;
      sample_q    <= '0;
      rsp_valid   <= 1'b0;
      rsp_status  <= '0;
      rsp_err     <= 1'b0;
      rsp_timeout <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        P_IDLE: if (req_valid) begin
          mask_q <= req_mask;
          st     <= P_KICK1;
        end
        P_KICK1: st <= P_WAIT1;
        P_WAIT1: if (eng_done) st <= P_KICK2;
        P_KICK2: st <= P_WAIT2;
        P_WAIT2: if (eng_done) begin
          sample_q <= eng_rx;
          st       <= P_EVAL;
        end
        P_EVAL: begin
          case (verdict)
            V_FAIL: begin
              rsp_valid   <= 1'b1;
              rsp_status  <= sample_q;
              rsp_err     <= 1'b1;
              rsp_timeout <= 1'b0;
              st          <= P_IDLE;
            end
            V_DONE: begin
              rsp_valid   <= 1'b1;
              rsp_status  <= sample_q;
              rsp_err     <= 1'b0;
              rsp_timeout <= 1'b0;
              st          <= P_IDLE;
            end
            default: begin
              if (budget_last) begin
                rsp_valid   <= 1'b1;
                rsp_status  <= sample_q;
                rsp_err     <= 1'b0;
                rsp_timeout <= 1'b1;
                st          <= P_IDLE;
              end else begin
                st <= P_KICK1;
              end
            end
          endcase
        end
        default: st <= P_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_status_poller.sv
module spi_status_poller
  import spsp_pkg::*;
#(
  parameter int MAX_SAMPLES = 10000,
  parameter int DIV_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [STAT_W-1:0] req_mask,
  output logic              rsp_valid,
  output logic [STAT_W-1:0] rsp_status,
  output logic              rsp_err,
  output logic              rsp_timeout,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  logic              eng_start, eng_done;
  logic [STAT_W-1:0] eng_rx;
  logic [STAT_W-1:0] sample_q, mask_q;
  verdict_t          verdict;
  logic              budget_last, cnt_clear, cnt_bump;

  spsp_byte_engine #(.DIV_W(DIV_W)) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .div     (clk_div),
    .start   (eng_start),
    .tx_byte (OPC_READ_STATUS),
    .done    (eng_done),
    .rx_byte (eng_rx),
    .sclk    (spi_sclk),
    .cs_n    (spi_cs_n),
    .mosi    (spi_mosi),
    .miso    (spi_miso)
  );

  spsp_status_judge u_judge (
    .sample  (sample_q),
    .mask    (mask_q),
    .verdict (verdict)
  );

  spsp_sample_counter #(.MAX_SAMPLES(MAX_SAMPLES)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (cnt_clear),
    .bump  (cnt_bump),
    .last  (budget_last)
  );

  spsp_poll_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_mask    (req_mask),
    .eng_start   (eng_start),
    .eng_done    (eng_done),
    .eng_rx      (eng_rx),
    .sample_q    (sample_q),
    .mask_q      (mask_q),
    .verdict     (verdict),
    .budget_last (budget_last),
    .cnt_clear   (cnt_clear),
    .cnt_bump    (cnt_bump),
    .rsp_valid   (rsp_valid),
    .rsp_status  (rsp_status),
    .rsp_err     (rsp_err),
    .rsp_timeout (rsp_timeout)
  );
endmodule

// File: rtl/spsp_poller_checks.sv
module spsp_poller_checks #(
  parameter int MAX_SAMPLES = 10000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [7:0] req_mask,
  input logic       rsp_valid,
  input logic [7:0] rsp_status,
  input logic       rsp_err,
  input logic       rsp_timeout,
  input logic       spi_sclk,
  input logic       spi_cs_n
);
  logic [7:0]  mask_cap;
  logic        cs_prev;
  logic [31:0] frames;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_cap <= '0;
      cs_prev  <= 1'b1;
      frames   <= '0;
    end else begin
      cs_prev <= spi_cs_n;
      if (req_valid && req_ready) begin
        mask_cap <= req_mask;
        frames   <= '0;
      end else if (cs_prev && !spi_cs_n) begin
        frames <= frames + 1;
      end
    end
  end

  p_sclk_low_when_deselected_r10: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  p_done_single_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_busy_blocks_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_err_needs_error_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> ((rsp_status[2] || rsp_status[3]) && !rsp_timeout));

  p_success_meets_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err && !rsp_timeout) |->
      (!rsp_status[0] && ((mask_cap == 8'h00) || ((rsp_status & mask_cap) != 8'h00))));

  p_timeout_uses_full_budget_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_timeout) |-> (frames == 32'(2 * MAX_SAMPLES)));

  p_frames_in_pairs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!frames[0] && frames != 32'd0));
endmodule

bind spi_status_poller spsp_poller_checks #(.MAX_SAMPLES(MAX_SAMPLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_mask    (req_mask),
  .rsp_valid   (rsp_valid),
  .rsp_status  (rsp_status),
  .rsp_err     (rsp_err),
  .rsp_timeout (rsp_timeout),
  .spi_sclk    (spi_sclk),
  .spi_cs_n    (spi_cs_n)
);

// File: tb/sim_spi_status_poller.sv
module sim_spi_status_poller;
  localparam int MAXS  = 6;
  localparam int DIV_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [DIV_W-1:0] clk_div = '0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [7:0]       req_mask = '0;
  logic             rsp_valid;
  logic [7:0]       rsp_status;
  logic             rsp_err, rsp_timeout;
  logic             spi_sclk, spi_cs_n, spi_mosi;
  logic             spi_miso = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0] script [0:MAXS-1];
  int         slv_frame = 0;
  logic [7:0] slv_sh = '0;

  int frames_seen = 0, sclk_rises = 0, sclk_hi = 0, mosi_bad = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b0;

  spi_status_poller #(.MAX_SAMPLES(MAXS), .DIV_W(DIV_W)) u0 (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div),
    .req_valid(req_valid), .req_ready(req_ready), .req_mask(req_mask),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_err(rsp_err), .rsp_timeout(rsp_timeout),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  always #5 clk = ~clk;

  // Target model: first frame of a pair returns a byte with both error bits set.
  always @(negedge spi_cs_n) begin
    if (slv_frame[0] == 1'b0) slv_sh = 8'h0F;
    else                      slv_sh = script[(slv_frame / 2 < MAXS) ? slv_frame / 2 : MAXS - 1];
    slv_frame = slv_frame + 1;
    spi_miso = slv_sh[7];
  end

  always @(negedge spi_sclk) begin
    if (!spi_cs_n) begin
      slv_sh = {slv_sh[6:0], 1'b0};
      spi_miso = slv_sh[7];
    end
  end

  always @(negedge clk) begin
    if (prev_cs && !spi_cs_n) frames_seen = frames_seen + 1;
    if (!prev_sclk && spi_sclk) begin
      sclk_rises = sclk_rises + 1;
      if (spi_mosi) mosi_bad = mosi_bad + 1;
    end
    if (spi_sclk) sclk_hi = sclk_hi + 1;
    prev_cs   = spi_cs_n;
    prev_sclk = spi_sclk;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
    end
  endtask

  task automatic model(input logic [7:0] mask, output int n, output logic [7:0] st,
                       output bit err, output bit to);
    err = 0; to = 0; n = 0; st = 8'h00;
    for (int i = 0; i < MAXS; i++) begin
      st = script[i];
      n  = i + 1;
      if (st[2] || st[3]) begin err = 1; break; end
      if (!st[0] && (mask == 8'h00 || (st & mask) != 8'h00)) break;
      if (i == MAXS - 1) to = 1;
    end
  endtask

  task automatic run_case(input logic [7:0] mask, input int d, input string tag);
    int n, lat, rdy_hits;
    logic [7:0] est;
    bit eerr, eto;
    string oreq;
    model(mask, n, est, eerr, eto);
    oreq = eerr ? "R4" : (eto ? "R7" : (n > 1 ? "R5" : "R6"));
    @(negedge clk);
    clk_div   = DIV_W'(d);
    req_mask  = mask;
    req_valid = 1'b1;
    @(posedge clk);
    slv_frame = 0; frames_seen = 0; sclk_rises = 0; sclk_hi = 0; mosi_bad = 0;
    lat = 0; rdy_hits = 0;
    @(negedge clk);
    req_valid = 1'b0;
    req_mask  = 8'hA5;
    forever begin
      if (rsp_valid) break;
      if (req_ready) rdy_hits++;
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    chk(rsp_status == est, oreq, {tag, " status"}, int'(rsp_status), int'(est));
    chk(rsp_err == eerr, oreq, {tag, " err flag"}, int'(rsp_err), int'(eerr));
    chk(rsp_timeout == eto, oreq, {tag, " timeout flag"}, int'(rsp_timeout), int'(eto));
    chk(lat == n * (34 * (d + 1) + 5), "R8", {tag, " latency"}, lat, n * (34 * (d + 1) + 5));
    chk(frames_seen == 2 * n, "R2", {tag, " frames"}, frames_seen, 2 * n);
    chk(sclk_rises == 16 * n, "R2", {tag, " sclk rises"}, sclk_rises, 16 * n);
    chk(mosi_bad == 0, "R2", {tag, " opcode bits"}, mosi_bad, 0);
    chk(sclk_hi == 16 * n * (d + 1), "R10", {tag, " sclk high cycles"}, sclk_hi, 16 * n * (d + 1));
    chk(rdy_hits == 0, "R9", {tag, " ready while busy"}, rdy_hits, 0);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R9", {tag, " done pulse width"}, int'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R9", {tag, " ready after done"}, int'(req_ready), 1);
  endtask

  function automatic logic [7:0] rand_status();
    logic [7:0] v;
    int c;
    v = {4'($urandom), 4'b0000};
    c = $urandom % 10;
    if (c < 4)       v[1:0] = {1'($urandom), 1'b1};
    else if (c < 7)  v[1]   = 1'b1;
    else if (c == 7) v[2]   = 1'b1;
    else if (c == 8) v[3]   = 1'b1;
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < MAXS; i++) script[i] = 8'h01;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "reset ready", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1", "reset done", int'(rsp_valid), 0);
    chk(spi_cs_n == 1'b1, "R1", "reset cs", int'(spi_cs_n), 1);
    chk(spi_sclk == 1'b0, "R1", "reset sclk", int'(spi_sclk), 0);
    rst_n = 1'b1;

    // R3: first-frame byte 0x0F would be an error; first judged byte is clean.
    script[0] = 8'h00;
    run_case(8'h00, 0, "R3 discard first byte, zero mask");
    script[0] = 8'h01; script[1] = 8'h01; script[2] = 8'h02;
    run_case(8'h02, 1, "R5 busy twice then ready");
    script[0] = 8'h00; script[1] = 8'h40; script[2] = 8'h02;
    run_case(8'h02, 0, "R6 mask miss then hit");
    script[0] = 8'h01; script[1] = 8'h04;
    run_case(8'h02, 2, "R4 violation bit");
    script[0] = 8'h09;
    run_case(8'h00, 0, "R4 error bit with busy");
    for (int i = 0; i < MAXS; i++) script[i] = 8'h01;
    script[MAXS-1] = 8'h81;
    run_case(8'h02, 0, "R7 timeout on busy");
    for (int i = 0; i < MAXS; i++) script[i] = 8'h20;
    run_case(8'h02, 1, "R7 timeout on mask miss");

    for (int t = 0; t < 24; t++) begin
      logic [7:0] m;
      for (int i = 0; i < MAXS; i++) script[i] = rand_status();
      m = ($urandom % 4 == 0) ? 8'h00 : 8'($urandom);
      run_case(m, int'($urandom % 4), "random");
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule